// File: doc/BRIEF.md
# TDM Transmit Slot Multiplexer

This block drives the transmit side of a serial time-division-multiplexed link that carries up to four slots per frame. An external strobe marks each bit period and a second input marks the first bit of a frame. The block counts bits and slots from these inputs. At the first bit of every slot that the transmit assignment mask gives to it, the block loads a shift register. It then sends that word out most significant bit first, one bit per strobe.

Each slot has its own choice of word source. The source is either a transmit FIFO that all slots share, or a holding register that belongs to that slot alone and is filled by a DMA engine. While a slot's holding register is empty, the block raises that slot's DMA request. While the FIFO holds no more words than a programmable warning limit, it raises an interrupt. Outside the assigned slots, and between the end of the last slot and the next frame start, the output enable is low so that the pad releases the line. If the chosen source has no word when a slot starts, the block sends zeros and sets a sticky underrun flag.

Top module: `tdm_tx_slot_mux`

## Requirements
- R1: After reset `sd_oe` and `sd_data` are 0, `fifo_level` is 0, `underrun` is 0, every bit of `dma_req` is 1, and `tx_irq` is 1 (an empty FIFO is at or below any limit).
- R2: A `bit_tick` with `frame_start` high begins slot 0, bit 0. Each slot lasts WORD_W ticks and slots follow in order 0,1,...,N_SLOTS-1. After the last bit of the last slot the block stays idle (`sd_oe` low) until the next `frame_start`.
- R3: During the bit ticks of slot i, `sd_oe` is 1 exactly when `tx_assign[i]` is 1. Bit i of the mask belongs to slot i. `sd_data` is 0 whenever `sd_oe` is 0.
- R4: In an assigned slot with `tx_dma_en[i]`=0, the word is the oldest FIFO entry. It is popped at the slot's first tick, and its bit WORD_W-1 is on `sd_data` after that tick. Lower bits follow on later ticks.
- R5: In an assigned slot with `tx_dma_en[i]`=1, the word is taken from slot i's DMA holding register, which then becomes empty. The FIFO is left untouched.
- R6: `dma_req[i]` is 1 while holding register i is empty. A `dma_wr[i]` pulse fills the register and clears the request on the next cycle.
- R7: `tx_irq` is 1 exactly when `fifo_level` is less than or equal to `warn_limit`, including the case where the two are equal.
- R8: If the chosen source is empty at the start of an assigned slot, the slot sends all zeros and `underrun` goes to 1. It stays 1 until reset.
- R9: A `fifo_push` while the FIFO holds FIFO_DEPTH words is dropped. The level stays at FIFO_DEPTH and the dropped word is never sent.
- R10: FIFO and DMA slots may be mixed in one frame. FIFO words go out in the order they were pushed, across slots and frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_tick | input | 1 | One-cycle strobe per serial bit period |
| frame_start | input | 1 | Qualifies a bit_tick as the first bit of a frame |
| tx_assign | input | N_SLOTS | Slot i is driven by this block when bit i is 1 |
| tx_dma_en | input | N_SLOTS | Slot i takes its word from its DMA register when bit i is 1, otherwise from the FIFO |
| warn_limit | input | LVL_W | FIFO level at or below which the interrupt is raised |
| fifo_push | input | 1 | Write strobe into the transmit FIFO |
| fifo_wdata | input | WORD_W | Word written into the FIFO |
| dma_wr | input | N_SLOTS | Write strobe, one per DMA holding register |
| dma_wdata | input | WORD_W | Word written into the selected DMA register |
| sd_data | output | 1 | Serial data bit |
| sd_oe | output | 1 | Output enable for the serial data pad; low means released |
| dma_req | output | N_SLOTS | Per-slot DMA request, high while that register is empty |
| tx_irq | output | 1 | FIFO low-level interrupt |
| underrun | output | 1 | Sticky flag: a slot started with its source empty |
| fifo_level | output | LVL_W | Number of words in the FIFO |

## Verification
The assertions assume that `frame_start` is only meaningful together with `bit_tick`. They also assume that `tx_assign` and `tx_dma_en` hold steady across a frame, and that at most one `dma_wr` bit is high at a time. The stimulus meets these conditions. Strobes go out as one-cycle pulses with an idle cycle between them. Mask and enable changes happen only between frames, and DMA writes address one register per pulse. The FIFO is deliberately overfilled and deliberately drained, so that both the dropped push and the empty-source case occur.

// File: rtl/tdm_tx_pkg.sv
// Package: shared constants and types for the TDM transmit slot multiplexer.
// Assumes nothing beyond IEEE 1800-2017.
package tdm_tx_pkg;

    // Largest number of slots a frame can carry.
    localparam int unsigned MAX_SLOTS = 4;

    // Word source chosen for a slot.
    typedef enum logic {
        SRC_FIFO = 1'b0,
        SRC_DMA  = 1'b1
    } src_sel_e;

endpackage

// File: rtl/tdm_tx_slot_timer.sv
// Module: tdm_tx_slot_timer
// Tracks the bit and slot position inside a frame from a bit strobe and a
// frame-start qualifier. It also flags the tick on which a slot begins.
// Assumes frame_start is only meaningful together with bit_tick.
module tdm_tx_slot_timer #(
    parameter int unsigned WORD_W  = 16,
    parameter int unsigned N_SLOTS = 4,
    localparam int unsigned SLOT_W = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1,
    localparam int unsigned BIT_W  = (WORD_W > 1) ? $clog2(WORD_W) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_tick,
    input  logic              frame_start,
    output logic              active,
    output logic [SLOT_W-1:0] slot,
    output logic [BIT_W-1:0]  bit_idx,
    output logic              slot_begin,
    output logic [SLOT_W-1:0] begin_slot
);

    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(N_SLOTS - 1);
    localparam logic [BIT_W-1:0]  LAST_BIT  = BIT_W'(WORD_W - 1);

    logic              nxt_active;
    logic [SLOT_W-1:0] nxt_slot;
    logic [BIT_W-1:0]  nxt_bit;

    // Purpose: work out the position that follows the current tick.
    always_comb begin
        nxt_active = active;
        nxt_slot   = slot;
        nxt_bit    = bit_idx;
        if (frame_start) begin
            nxt_active = 1'b1;
            nxt_slot   = '0;
            nxt_bit    = '0;
        end else if (active) begin
            if (bit_idx == LAST_BIT) begin
                nxt_bit = '0;
                if (slot == LAST_SLOT) begin
                    nxt_active = 1'b0;
                    nxt_slot   = '0;
                end else begin
                    nxt_slot = slot + 1'b1;
                end
            end else begin
                nxt_bit = bit_idx + 1'b1;
            end
        end
    end

    // Purpose: a slot begins on a tick that lands on bit 0 of an active slot.
    always_comb begin
        slot_begin = bit_tick && nxt_active && (nxt_bit == '0);
        begin_slot = nxt_slot;
    end

    // Purpose: advance the position register once per bit tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active  <= 1'b0;
            slot    <= '0;
            bit_idx <= '0;
        end else if (bit_tick) begin
            active  <= nxt_active;
            slot    <= nxt_slot;
            bit_idx <= nxt_bit;
        end
    end

    AST_FRAME_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        bit_tick && frame_start |=> active && slot == '0 && bit_idx == '0); // R2
    AST_HOLD_WITHOUT_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_tick |=> $stable(active) && $stable(slot) && $stable(bit_idx)); // R2

endmodule

// File: rtl/tdm_tx_fifo.sv
// Module: tdm_tx_fifo
// Shared transmit FIFO with a head word visible combinationally.
// A push while full is dropped and a pop while empty is ignored.
// Assumes DEPTH is a power of two.
module tdm_tx_fifo #(
    parameter int unsigned WORD_W = 16,
    parameter int unsigned DEPTH  = 8,
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int unsigned LVL_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [WORD_W-1:0] wdata,
    input  logic              pop,
    output logic [WORD_W-1:0] head,
    output logic              empty,
    output logic              full,
    output logic [LVL_W-1:0]  level
);

    localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);

    logic [WORD_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wr_ptr;
    logic [PTR_W-1:0]  rd_ptr;
    logic              do_push;
    logic              do_pop;

    // Purpose: derive status and qualified strobes.
    always_comb begin
        empty   = (level == '0);
        full    = (level == FULL_LVL);
        do_push = push && !full;
        do_pop  = pop && !empty;
        head    = mem[rd_ptr];
    end

    // Purpose: store pushed words.
    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wr_ptr] <= wdata;
        end
    end

    // Purpose: maintain the pointers and the occupancy count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (do_push) wr_ptr <= wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
        end
    end

    AST_FIFO_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        level <= FULL_LVL); // R9
    AST_FIFO_DROP_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        full && push && !pop |=> level == FULL_LVL); // R9

endmodule

// File: rtl/tdm_tx_dma_regs.sv
// Module: tdm_tx_dma_regs
// One holding register per slot with a full flag. A write fills the register
// and a take empties it. A write in the same cycle as a take wins.
// Assumes take is one-hot or zero.
module tdm_tx_dma_regs #(
    parameter int unsigned WORD_W  = 16,
    parameter int unsigned N_SLOTS = 4
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [N_SLOTS-1:0]             wr,
    input  logic [WORD_W-1:0]              wdata,
    input  logic [N_SLOTS-1:0]             take,
    output logic [N_SLOTS-1:0][WORD_W-1:0] q,
    output logic [N_SLOTS-1:0]             full
);

    for (genvar i = 0; i < N_SLOTS; i++) begin : g_reg
        // Purpose: hold slot i's word and its occupancy flag.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q[i]    <= '0;
                full[i] <= 1'b0;
            end else if (wr[i]) begin
                q[i]    <= wdata;
                full[i] <= 1'b1;
            end else if (take[i]) begin
                full[i] <= 1'b0;
            end
        end

        AST_DMA_EMPTY_AFTER_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
            take[i] && !wr[i] |=> !full[i]); // R6
        AST_DMA_FULL_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
            wr[i] |=> full[i]); // R6
    end

endmodule

// File: rtl/tdm_tx_slot_mux.sv
// Module: tdm_tx_slot_mux (top)
// Drives a serial TDM output of up to N_SLOTS slots per frame. At the first
// tick of each assigned slot the shift register is loaded from the FIFO or
// from that slot's DMA register, then shifted out MSB first. The output
// enable follows the current slot's assignment bit.
// Assumes tx_assign and tx_dma_en stay steady within a frame.
module tdm_tx_slot_mux
    import tdm_tx_pkg::*;
#(
    parameter int unsigned WORD_W     = 16,
    parameter int unsigned N_SLOTS    = 4,
    parameter int unsigned FIFO_DEPTH = 8,
    localparam int unsigned LVL_W     = $clog2(FIFO_DEPTH + 1),
    localparam int unsigned SLOT_W    = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1,
    localparam int unsigned BIT_W     = (WORD_W > 1) ? $clog2(WORD_W) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bit_tick,
    input  logic               frame_start,
    input  logic [N_SLOTS-1:0] tx_assign,
    input  logic [N_SLOTS-1:0] tx_dma_en,
    input  logic [LVL_W-1:0]   warn_limit,
    input  logic               fifo_push,
    input  logic [WORD_W-1:0]  fifo_wdata,
    input  logic [N_SLOTS-1:0] dma_wr,
    input  logic [WORD_W-1:0]  dma_wdata,
    output logic               sd_data,
    output logic               sd_oe,
    output logic [N_SLOTS-1:0] dma_req,
    output logic               tx_irq,
    output logic               underrun,
    output logic [LVL_W-1:0]   fifo_level
);

    logic                           tm_active;
    logic [SLOT_W-1:0]              tm_slot;
    logic [BIT_W-1:0]               tm_bit;
    logic                           tm_begin;
    logic [SLOT_W-1:0]              tm_begin_slot;

    logic [WORD_W-1:0]              fifo_head;
    logic                           fifo_empty;
    logic                           fifo_full;
    logic                           fifo_pop;

    logic [N_SLOTS-1:0][WORD_W-1:0] dma_q;
    logic [N_SLOTS-1:0]             dma_full;
    logic [N_SLOTS-1:0]             dma_take;

    logic                           load;
    src_sel_e                       src;
    logic                           src_ok;
    logic [WORD_W-1:0]              load_word;
    logic [WORD_W-1:0]              shreg;

    tdm_tx_slot_timer #(
        .WORD_W  (WORD_W),
        .N_SLOTS (N_SLOTS)
    ) u_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .bit_tick    (bit_tick),
        .frame_start (frame_start),
        .active      (tm_active),
        .slot        (tm_slot),
        .bit_idx     (tm_bit),
        .slot_begin  (tm_begin),
        .begin_slot  (tm_begin_slot)
    );

    tdm_tx_fifo #(
        .WORD_W (WORD_W),
        .DEPTH  (FIFO_DEPTH)
    ) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (fifo_push),
        .wdata (fifo_wdata),
        .pop   (fifo_pop),
        .head  (fifo_head),
        .empty (fifo_empty),
        .full  (fifo_full),
        .level (fifo_level)
    );

    tdm_tx_dma_regs #(
        .WORD_W  (WORD_W),
        .N_SLOTS (N_SLOTS)
    ) u_dma (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (dma_wr),
        .wdata (dma_wdata),
        .take  (dma_take),
        .q     (dma_q),
        .full  (dma_full)
    );

    // Purpose: choose the source for a starting slot and its load word.
    always_comb begin
        load      = tm_begin && tx_assign[tm_begin_slot];
        src       = tx_dma_en[tm_begin_slot] ? SRC_DMA : SRC_FIFO;
        src_ok    = (src == SRC_DMA) ? dma_full[tm_begin_slot] : !fifo_empty;
        load_word = '0;
        if (src_ok) begin
            load_word = (src == SRC_DMA) ? dma_q[tm_begin_slot] : fifo_head;
        end
        fifo_pop = load && (src == SRC_FIFO) && !fifo_empty;
        dma_take = '0;
        if (load && (src == SRC_DMA)) begin
            dma_take[tm_begin_slot] = 1'b1;
        end
    end

    // Purpose: load at slot start, otherwise shift left one bit per tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg <= '0;
        end else if (bit_tick) begin
            if (load) shreg <= load_word;
            else      shreg <= {shreg[WORD_W-2:0], 1'b0};
        end
    end

    // Purpose: latch an underrun until reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            underrun <= 1'b0;
        end else if (load && !src_ok) begin
            underrun <= 1'b1;
        end
    end

    // Purpose: drive the pad from the slot position and raise the requests.
    always_comb begin
        sd_oe   = tm_active && tx_assign[tm_slot];
        sd_data = sd_oe && shreg[WORD_W-1];
        dma_req = ~dma_full;
        tx_irq  = (fifo_level <= warn_limit);
    end

    AST_NO_DRIVE_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !tm_active |-> !sd_oe && !sd_data); // R3
    AST_UNDERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        underrun |=> underrun); // R8
    AST_UNDERRUN_SENDS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        bit_tick && load && !src_ok |=> !sd_data); // R8
    AST_FIFO_UNTOUCHED_BY_DMA: assert property (@(posedge clk) disable iff (!rst_n)
        load && src == SRC_DMA && !fifo_push |=> $stable(fifo_level)); // R5

endmodule

// File: tb/tdm_tx_slot_mux_tb.sv
// Scoreboard bench: the frame driver pushes the expected {oe,data} of every
// tick into a queue, and the monitor pops and compares after each tick.
module tdm_tx_slot_mux_tb_top;

    localparam int W  = 16;
    localparam int NS = 4;
    localparam int FD = 8;
    localparam int LW = $clog2(FD + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bit_tick = 1'b0;
    logic          frame_start = 1'b0;
    logic [NS-1:0] tx_assign = '0;
    logic [NS-1:0] tx_dma_en = '0;
    logic [LW-1:0] warn_limit = LW'(2);
    logic          fifo_push = 1'b0;
    logic [W-1:0]  fifo_wdata = '0;
    logic [NS-1:0] dma_wr = '0;
    logic [W-1:0]  dma_wdata = '0;
    logic          sd_data;
    logic          sd_oe;
    logic [NS-1:0] dma_req;
    logic          tx_irq;
    logic          underrun;
    logic [LW-1:0] fifo_level;

    int vectors = 0;
    int errors  = 0;

    logic [1:0] sb_q [$];
    logic [W-1:0] m_fifo [$];
    logic [W-1:0] m_dma [NS];
    logic         m_full [NS];
    logic         m_underrun = 1'b0;
    logic         tick_q = 1'b0;

    always #10 clk = ~clk;

    tdm_tx_slot_mux #(.WORD_W(W), .N_SLOTS(NS), .FIFO_DEPTH(FD)) dut_i (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .frame_start(frame_start),
        .tx_assign(tx_assign), .tx_dma_en(tx_dma_en), .warn_limit(warn_limit),
        .fifo_push(fifo_push), .fifo_wdata(fifo_wdata), .dma_wr(dma_wr),
        .dma_wdata(dma_wdata), .sd_data(sd_data), .sd_oe(sd_oe), .dma_req(dma_req),
        .tx_irq(tx_irq), .underrun(underrun), .fifo_level(fifo_level)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Monitor: remember which cycles carried a tick.
    always @(posedge clk) tick_q <= bit_tick;

    // Monitor: compare the line after every tick against the scoreboard.
    always @(negedge clk) begin
        if (tick_q) begin
            if (sb_q.size() == 0) begin
                check(1'b0, "R2 scoreboard empty", int'({sd_oe, sd_data}), 0);
            end else begin
                logic [1:0] e;
                e = sb_q.pop_front();
                check({sd_oe, sd_data} == e, "R2/R3/R4/R5 line", int'({sd_oe, sd_data}), int'(e));
            end
        end
    end

    task automatic tick(input logic fs);
        @(negedge clk);
        bit_tick = 1'b1;
        frame_start = fs;
        @(negedge clk);
        bit_tick = 1'b0;
        frame_start = 1'b0;
    endtask

    task automatic push_word(input logic [W-1:0] w);
        @(negedge clk);
        fifo_push = 1'b1;
        fifo_wdata = w;
        if (m_fifo.size() < FD) m_fifo.push_back(w);
        @(negedge clk);
        fifo_push = 1'b0;
    endtask

    task automatic dma_write(input int i, input logic [W-1:0] w);
        @(negedge clk);
        dma_wr = '0;
        dma_wr[i] = 1'b1;
        dma_wdata = w;
        m_dma[i] = w;
        m_full[i] = 1'b1;
        @(negedge clk);
        dma_wr = '0;
    endtask

    // Driver: run one frame and push the expected line value of every tick.
    task automatic run_frame(input int idle_ticks);
        for (int s = 0; s < NS; s++) begin
            logic [W-1:0] word;
            word = '0;
            if (tx_assign[s]) begin
                if (tx_dma_en[s]) begin
                    if (m_full[s]) begin word = m_dma[s]; m_full[s] = 1'b0; end
                    else m_underrun = 1'b1;
                end else begin
                    if (m_fifo.size() > 0) word = m_fifo.pop_front();
                    else m_underrun = 1'b1;
                end
            end
            for (int b = W - 1; b >= 0; b--) begin
                sb_q.push_back(tx_assign[s] ? {1'b1, word[b]} : 2'b00);
                tick(s == 0 && b == W - 1);
            end
        end
        for (int k = 0; k < idle_ticks; k++) begin
            sb_q.push_back(2'b00);
            tick(1'b0);
        end
        @(negedge clk);
    endtask

    task automatic finish_run;
        check(sb_q.size() == 0, "R2 scoreboard drained", sb_q.size(), 0);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < NS; i++) begin m_full[i] = 1'b0; m_dma[i] = '0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        check(sd_oe == 1'b0 && sd_data == 1'b0, "R1 line", int'({sd_oe, sd_data}), 0);
        check(dma_req == 4'b1111, "R1 dma_req", dma_req, 4'hf);
        check(fifo_level == 0 && underrun == 1'b0, "R1 level/underrun", int'({fifo_level, underrun}), 0);
        check(tx_irq == 1'b1, "R1 irq", tx_irq, 1);
        rst_n = 1'b1;

        // R9 fill the FIFO then overfill it by one
        for (int k = 0; k < FD; k++) push_word(16'hA000 + 16'(k * 16'h0111));
        push_word(16'hDEAD);
        @(negedge clk);
        check(fifo_level == LW'(FD), "R9 level after overfill", fifo_level, FD);
        check(tx_irq == 1'b0, "R7 irq low above limit", tx_irq, 0);

        // R4 R2 all slots from the FIFO, then idle ticks
        tx_assign = 4'b1111; tx_dma_en = 4'b0000;
        run_frame(4);
        check(fifo_level == 4, "R4 level after frame", fifo_level, 4);

        // R5 R10 mixed frame: slot0 FIFO, slot2 DMA, slots 1 and 3 released
        dma_write(2, 16'h5A3C);
        @(negedge clk);
        check(dma_req == 4'b1011, "R6 request cleared by write", dma_req, 4'hb);
        tx_assign = 4'b0101; tx_dma_en = 4'b0100;
        run_frame(2);
        check(dma_req == 4'b1111, "R6 request after take", dma_req, 4'hf);
        check(fifo_level == 3, "R5 FIFO untouched by DMA slot", fifo_level, 3);
        check(underrun == 1'b0, "R8 no underrun yet", underrun, 0);
        warn_limit = LW'(3);
        @(negedge clk);
        check(tx_irq == 1'b1, "R7 irq at equal limit", tx_irq, 1);

        // R8 R9 drain the FIFO: slot 3 finds it empty and the dropped word never shows
        tx_assign = 4'b1111; tx_dma_en = 4'b0000;
        run_frame(2);
        check(underrun == 1'b1, "R8 underrun set", underrun, 1);
        check(fifo_level == 0 && tx_irq == 1'b1, "R7 irq when empty", int'({fifo_level, tx_irq}), 1);

        // R5 R8 all DMA, slots 2 and 3 empty, flag stays set
        tx_dma_en = 4'b1111;
        dma_write(0, 16'h8001);
        dma_write(1, 16'h7FFE);
        run_frame(2);
        check(underrun == m_underrun && underrun == 1'b1, "R8 underrun sticky", underrun, 1);
        check(dma_req == 4'b1111, "R6 all requests", dma_req, 4'hf);

        finish_run();
    end

endmodule